// File: doc/BRIEF.md
# Saturating Left Shifter with Status Flags

This unit performs an arithmetic left shift for a DSP datapath on one of three operand widths: a 16-bit halfword, a 32-bit word or a 40-bit accumulator. A fourth mode shifts the two 16-bit halves of a word side by side. Each request is presented with a valid strobe. On the next clock edge the unit registers the shifted value together with negative, zero, overflow and sticky-overflow flags.

Two controls act independently. The saturate enable clamps an out-of-range result to the largest positive or negative value. The overflow-report enable decides whether the detected overflow reaches the overflow flags. Accumulator-width shifts never saturate and never touch either overflow flag. The sticky flag accumulates overflow reports until a synchronous clear is applied.

Mode codes on `mode_i`: 0 = 16-bit, 1 = 32-bit, 2 = 40-bit accumulator, 3 = dual halfword.

Top module: `sat_lshift`

## Requirements
- R1: The shift amount used is `amt_i` limited to the operand width. Any larger amount gives the same result and flags as a shift by the full width.
- R2: Raw overflow of a lane is clear when every bit shifted out above the lane width is 0. It is also clear when every such bit is 1 and the result's top bit is 1. In all other cases it is set.
- R3: In mode 0 with `sat_i`=1, the result becomes 0x7FFF (input bit 15 = 0) or 0x8000 (input bit 15 = 1) when raw overflow is set or when result bit 15 differs from input bit 15. Raw overflow then counts as set.
- R4: In mode 1 with `sat_i`=1, the result becomes 0x7FFFFFFF or 0x80000000, chosen by input bit 31, under any of these conditions: raw overflow is set; some shifted-out bit or result bit 31 differs from input bit 31; or a nonzero non-negative input gives a zero result. Raw overflow then counts as set.
- R5: In mode 2 the result is the 40-bit operand shifted and truncated to 40 bits, with no saturation whatever `sat_i` is.
- R6: `neg_o` is the result's top bit at the selected width. `zero_o` is 1 when the result is zero.
- R7: In modes 0, 1 and 3, a request writes `ovf_o` with `ovf_en_i` AND raw overflow, so `ovf_o` is 0 whenever `ovf_en_i` is 0.
- R8: `sticky_o` is set by any request that writes `ovf_o` as 1. It is held otherwise and cleared only by `clr_sticky_i`. A set and a clear in the same cycle leave it 1.
- R9: A mode 2 request leaves `ovf_o` and `sticky_o` unchanged.
- R10: In mode 3, bits 15:0 and 31:16 are shifted as two independent 16-bit lanes by the same amount, with result bits 39:32 zero. `neg_o`, `zero_o` and raw overflow are the OR of the two lanes' flags.
- R11: All outputs reset to 0. The result, `neg_o` and `zero_o` change only on the clock edge where `valid_i` is 1, and they appear one cycle after that edge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | Width select (0:16, 1:32, 2:40, 3:dual 16) |
| sat_i | input | 1 | Saturate enable |
| ovf_en_i | input | 1 | Overflow-report enable |
| clr_sticky_i | input | 1 | Synchronous clear of sticky flag |
| amt_i | input | 6 | Left shift amount |
| operand_i | input | 40 | Operand, low bits used for narrow modes |
| result_o | output | 40 | Registered shifted value |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Overflow flag |
| sticky_o | output | 1 | Sticky overflow flag |

## Verification
Every output is due exactly one clock edge after the request is sampled. The bench drives each request on a falling edge, lets one rising edge pass and compares all five outputs on the next falling edge. A behavioural model advances its own copy of the registered state at the same point, so the comparison runs on every clock, including idle cycles where the outputs must hold. Directed literal checks at the same sampling point cover the saturation limits, amounts at and beyond the width, and sticky set/clear ordering.

// File: rtl/sat_lshift.sv
module sat_lshift (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [1:0]  mode_i,
  input  logic        sat_i,
  input  logic        ovf_en_i,
  input  logic        clr_sticky_i,
  input  logic [5:0]  amt_i,
  input  logic [39:0] operand_i,
  output logic [39:0] result_o,
  output logic        neg_o,
  output logic        zero_o,
  output logic        ovf_o,
  output logic        sticky_o
);
  localparam logic [1:0] M16 = 2'd0, M32 = 2'd1, M40 = 2'd2, MDUAL = 2'd3;
  localparam int XW = 80;

  // returns {raw_ovf, result}
  function automatic logic [40:0] lane(input logic [39:0] v, input logic [5:0] amt,
                                       input int sz, input logic sat);
    logic [XW-1:0] ext, sh, top, ones, keep, hi, hexp;
    logic [39:0]   res;
    logic          sgn, nmsb, ovf;
    int            c;
    c    = (int'(amt) > sz) ? sz : int'(amt);
    keep = (XW'(1) << sz) - XW'(1);
    ext  = XW'(v) & keep;
    sh   = ext << c;
    top  = sh >> sz;
    res  = 40'(sh & keep);
    sgn  = ext[sz-1];
    nmsb = res[sz-1];
    ones = (XW'(1) << c) - XW'(1);
    ovf  = !((top == '0) || (top == ones && nmsb));
    if (sat && sz == 16 && (ovf || sgn != nmsb)) begin
      res = sgn ? 40'h8000 : 40'h7FFF;
      ovf = 1'b1;
    end
    if (sat && sz == 32) begin
      hi   = sh >> 31;
      hexp = sgn ? ((XW'(1) << (c + 1)) - XW'(1)) : '0;
      if (ovf || hi != hexp || (!sgn && res == '0 && ext != '0)) begin
        res = sgn ? 40'h80000000 : 40'h7FFFFFFF;
        ovf = 1'b1;
      end
    end
    return {ovf, res};
  endfunction

  logic [40:0] l16, l32, l40, llo, lhi;
  logic [39:0] nres;
  logic        nneg, nzero, nraw, acc, ovf_term;

  assign l16 = lane(operand_i, amt_i, 16, sat_i);
  assign l32 = lane(operand_i, amt_i, 32, sat_i);
  assign l40 = lane(operand_i, amt_i, 40, 1'b0);
  assign llo = lane({24'd0, operand_i[15:0]}, amt_i, 16, sat_i);
  assign lhi = lane({24'd0, operand_i[31:16]}, amt_i, 16, sat_i);

  always_comb begin
    unique case (mode_i)
      M16: begin
        nres = l16[39:0]; nneg = l16[15]; nzero = (l16[15:0] == '0); nraw = l16[40];
      end
      M32: begin
        nres = l32[39:0]; nneg = l32[31]; nzero = (l32[31:0] == '0); nraw = l32[40];
      end
      M40: begin
        nres = l40[39:0]; nneg = l40[39]; nzero = (l40[39:0] == '0); nraw = 1'b0;
      end
      default: begin
        nres  = {8'd0, lhi[15:0], llo[15:0]};
        nneg  = lhi[15] | llo[15];
        nzero = (lhi[15:0] == '0) | (llo[15:0] == '0);
        nraw  = lhi[40] | llo[40];
      end
    endcase
  end

  assign acc      = (mode_i == M40);
  assign ovf_term = valid_i & ~acc & ovf_en_i & nraw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b0;
      ovf_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      if (valid_i) begin
        result_o <= nres;
        neg_o    <= nneg;
        zero_o   <= nzero;
        if (!acc) ovf_o <= ovf_term;
      end
      sticky_o <= (sticky_o & ~clr_sticky_i) | ovf_term;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_o && !clr_sticky_i) |=> sticky_o); // R8
  AST_OVF_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> sticky_o); // R8
  AST_ACC_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == M40) |=> $stable(ovf_o)); // R9
  AST_NO_OVF_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i != M40 && !ovf_en_i) |=> !ovf_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(result_o) && $stable(neg_o) && $stable(zero_o))); // R11
  AST_DUAL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == MDUAL) |=> (result_o[39:32] == 8'd0)); // R10
endmodule

// File: tb/sat_lshift_tb_top.sv
`timescale 1ns/1ps
module sat_lshift_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        sat_i = 1'b0, ovf_en_i = 1'b0, clr_sticky_i = 1'b0;
  logic [5:0]  amt_i = '0;
  logic [39:0] operand_i = '0;
  logic [39:0] result_o;
  logic        neg_o, zero_o, ovf_o, sticky_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [39:0] m_res = '0;
  logic        m_neg = 0, m_zero = 0, m_ovf = 0, m_sticky = 0;

  always #2.5 clk = ~clk;

  sat_lshift dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ref_lane(input logic [39:0] v, input int a, input int sz, input bit sat,
                          output logic [39:0] r, output bit ov);
    logic [63:0] vm;
    int c, n1;
    bit sg, bad;
    vm = 64'(v) & ((64'd1 << sz) - 1);
    c  = (a > sz) ? sz : a;
    n1 = 0; bad = 0;
    sg = vm[sz-1];
    for (int k = 0; k < c; k++) begin
      if (vm[sz-1-k]) n1++;
      if (vm[sz-1-k] != sg) bad = 1;
    end
    r  = 40'((vm << c) & ((64'd1 << sz) - 1));
    ov = !((n1 == 0) || (n1 == c && r[sz-1]));
    if (sat && sz == 16 && (ov || r[15] != sg)) begin
      r = sg ? 40'h8000 : 40'h7FFF; ov = 1;
    end
    if (sat && sz == 32 && (ov || bad || r[31] != sg || (!sg && r == 0 && vm != 0))) begin
      r = sg ? 40'h80000000 : 40'h7FFFFFFF; ov = 1;
    end
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input bit v, input logic [1:0] m, input bit s, input bit oe,
                      input bit clr, input int a, input logic [39:0] op);
    logic [39:0] r, rl, rh;
    bit o, ol, oh, ng, zr, term;
    valid_i = v; mode_i = m; sat_i = s; ovf_en_i = oe; clr_sticky_i = clr;
    amt_i = 6'(a); operand_i = op;
    case (m)
      2'd0: begin ref_lane(op, a, 16, s, r, o); ng = r[15]; zr = (r[15:0] == 0); end
      2'd1: begin ref_lane(op, a, 32, s, r, o); ng = r[31]; zr = (r[31:0] == 0); end
      2'd2: begin ref_lane(op, a, 40, 0, r, o); ng = r[39]; zr = (r == 0); o = 0; end
      default: begin
        ref_lane({24'd0, op[15:0]}, a, 16, s, rl, ol);
        ref_lane({24'd0, op[31:16]}, a, 16, s, rh, oh);
        r = {8'd0, rh[15:0], rl[15:0]};
        ng = rl[15] | rh[15]; zr = (rl[15:0] == 0) | (rh[15:0] == 0); o = ol | oh;
      end
    endcase
    term = v && m != 2'd2 && oe && o;
    if (v) begin
      m_res = r; m_neg = ng; m_zero = zr;
      if (m != 2'd2) m_ovf = term;
    end
    m_sticky = (m_sticky && !clr) || term;
    @(posedge clk);
    @(negedge clk);
    chk({tag_of(m), " result"}, 64'(result_o), 64'(m_res));
    chk("R6 neg", 64'(neg_o), 64'(m_neg));
    chk("R6 zero", 64'(zero_o), 64'(m_zero));
    chk(m == 2'd2 ? "R9 ovf" : "R7 ovf", 64'(ovf_o), 64'(m_ovf));
    chk("R8 sticky", 64'(sticky_o), 64'(m_sticky));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset result", 64'(result_o), 64'd0);
    chk("R11 reset sticky", 64'(sticky_o), 64'd0);

    step(1, 0, 1, 1, 0, 1, 40'h4000);
    chk("R3 pos clamp", 64'(result_o), 64'h7FFF);
    chk("R3 forced ovf", 64'(ovf_o), 64'd1);
    step(1, 0, 1, 1, 0, 1, 40'h8000);
    chk("R3 neg clamp", 64'(result_o), 64'h8000);
    step(1, 0, 1, 1, 0, 0, 40'h7FFF);
    chk("R3 amt0 no clamp", 64'(result_o), 64'h7FFF);
    chk("R3 amt0 ovf", 64'(ovf_o), 64'd0);
    step(1, 0, 0, 1, 0, 4, 40'hFFFF);
    chk("R2 ones out msb1", 64'(ovf_o), 64'd0);
    chk("R2 result", 64'(result_o), 64'hFFF0);
    step(1, 0, 0, 1, 0, 4, 40'h0800);
    chk("R2 zeros out", 64'(ovf_o), 64'd0);
    step(1, 0, 0, 1, 0, 4, 40'h1800);
    chk("R2 mixed out", 64'(ovf_o), 64'd1);
    step(1, 0, 0, 1, 0, 50, 40'h0001);
    chk("R1 amt beyond width", 64'(result_o), 64'd0);
    chk("R1 zero flag", 64'(zero_o), 64'd1);
    step(1, 0, 0, 1, 0, 16, 40'h0000);
    chk("R1 full width zero input", 64'(ovf_o), 64'd0);
    step(1, 1, 1, 1, 0, 1, 40'h40000000);
    chk("R4 sign change clamp", 64'(result_o), 64'h7FFFFFFF);
    step(1, 1, 1, 0, 0, 1, 40'hC0000000);
    chk("R4 no clamp", 64'(result_o), 64'h80000000);
    chk("R7 report off", 64'(ovf_o), 64'd0);
    chk("R8 sticky held", 64'(sticky_o), 64'd1);
    step(1, 2, 1, 1, 0, 1, 40'h8000000001);
    chk("R5 truncate", 64'(result_o), 64'h2);
    chk("R9 ovf kept", 64'(ovf_o), 64'd0);
    step(1, 3, 0, 1, 0, 1, 40'h40000001);
    chk("R10 dual result", 64'(result_o), 64'h80000002);
    chk("R10 dual neg", 64'(neg_o), 64'd1);
    step(0, 0, 0, 1, 1, 0, 40'h0);
    chk("R8 cleared", 64'(sticky_o), 64'd0);
    chk("R11 idle hold", 64'(result_o), 64'h80000002);
    step(1, 0, 0, 1, 1, 4, 40'h1800);
    chk("R8 set beats clear", 64'(sticky_o), 64'd1);
    step(1, 0, 0, 1, 0, 4, 40'h1800);
    step(1, 2, 0, 1, 0, 3, 40'hF000000000);
    chk("R9 ovf kept set", 64'(ovf_o), 64'd1);

    for (int i = 0; i < 4000; i++) begin
      logic [39:0] op;
      op = {$urandom, $urandom};
      case ($urandom_range(0, 5))
        0: op = 40'h8000;
        1: op = 40'h7FFF;
        2: op = 40'h0;
        default: ;
      endcase
      step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), 1'($urandom),
           1'($urandom), $urandom_range(0, 15) == 0, $urandom_range(0, 63), op);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule